// File: doc/BRIEF.md
# Double-Precision Compare Flag Generator

This block compares two double-precision IEEE-754 values and turns the result into a three-bit condition code. The code describes one of four outcomes: greater, less, equal, or unordered. The block also drives three arithmetic status bits that are always cleared. Each operand port is wider than one double, and only the lowest 64 bits take part in the compare.

The block checks each operation for two exceptions: an invalid operand and a denormal operand. A mode input decides which NaNs count as invalid. Each exception has its own mask input. When a raised exception is not masked, the block requests exception handling and leaves the status bits as they were.

A caller gives one operation with a single-cycle `in_valid` pulse. One clock later the registered result appears with a one-cycle `out_valid` pulse. There is no back-pressure, so a new operation may start on every cycle.

Top module: `fcmp_flag_unit`

## Requirements
- R1: Only bits [63:0] of each operand port take part in the compare. The upper bits have no effect on any output.
- R2: An `in_valid` in cycle N produces `out_valid` high in cycle N+1 only. All outputs except the pulses hold their values between operations.
- R3: On a flag write, {`flag_zf`,`flag_pf`,`flag_cf`} is written as follows: 000 for greater (a > b), 001 for less, 100 for equal, and 111 for unordered. `flag_of`, `flag_sf` and `flag_af` are always 0.
- R4: An operand is a NaN when its exponent bits [62:52] are all ones and its fraction bits [51:0] are nonzero. If either operand is a NaN, the result is unordered.
- R5: +0.0 and -0.0 compare as equal in every sign combination.
- R6: Ordered operands are ranked by sign first and then by magnitude. Infinities rank above every finite value. Denormals rank by their magnitude. When both operands are negative, the magnitude order is reversed.
- R7: `exc_inv` is set for an operation as follows. With `sig_mode`=0, it is set only when an operand is a signalling NaN, which is a NaN with fraction bit 51 equal to 0. With `sig_mode`=1, it is set for any NaN.
- R8: `exc_den` is set for an operation when either operand is denormal: exponent zero and fraction nonzero. This is independent of `exc_inv`.
- R9: A mask input of 1 masks its exception. If a raised exception is unmasked, `exc_req` pulses with `out_valid`, `flag_we` stays low, and all six status bits keep their previous values. Otherwise `flag_we` pulses with `out_valid` and the status bits are written.
- R10: While `rst` is high, all outputs are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Starts one compare |
| opnd_a | input | OPND_W | First operand; low FP_W bits used |
| opnd_b | input | OPND_W | Second operand; low FP_W bits used |
| sig_mode | input | 1 | 1: any NaN is invalid; 0: only signalling NaNs |
| mask_inv | input | 1 | 1 masks the invalid exception |
| mask_den | input | 1 | 1 masks the denormal exception |
| out_valid | output | 1 | One-cycle result pulse |
| flag_we | output | 1 | Status bits were written this cycle |
| exc_req | output | 1 | Unmasked exception request pulse |
| exc_inv | output | 1 | Invalid seen in last operation |
| exc_den | output | 1 | Denormal seen in last operation |
| flag_zf | output | 1 | Zero/equal status bit |
| flag_pf | output | 1 | Parity/unordered status bit |
| flag_cf | output | 1 | Carry/less status bit |
| flag_of | output | 1 | Overflow status bit, always 0 |
| flag_sf | output | 1 | Sign status bit, always 0 |
| flag_af | output | 1 | Adjust status bit, always 0 |

## Verification
The block has one register stage, so a wrong classification or ordering appears at the ports in the cycle right after the operation. It shows up as a wrong condition code, a wrong exception bit, or a write pulse where a request pulse belongs. Wrong hold behaviour shows up during idle cycles, because stale or cleared status bits are compared on every clock. The stimulus covers signed zeros, infinities, denormals, both NaN kinds in both modes, and every mask combination. These are the places where a miscoded sign, exponent or fraction field would disagree with the reference model.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LT = 2'd1,
    CMP_EQ = 2'd2,
    CMP_UN = 2'd3
  } cmp_res_e;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_zero;
    logic is_denorm;
  } opnd_class_t;

  // condition code {zf, pf, cf} for each outcome
  function automatic logic [2:0] cc_of(cmp_res_e r);
    case (r)
      CMP_GT:  cc_of = 3'b000;
      CMP_LT:  cc_of = 3'b001;
      CMP_EQ:  cc_of = 3'b100;
      default: cc_of = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int FP_W  = 64,
  parameter int EXP_W = 11
) (
  input  logic [FP_W-1:0] val,
  output opnd_class_t     cls,
  output logic [FP_W-2:0] mag
);
  localparam int FRAC_W = FP_W - 1 - EXP_W;

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic exp_ones, exp_zero, frac_nz;

  assign expo     = val[FP_W-2 -: EXP_W];
  assign frac     = val[FRAC_W-1:0];
  assign exp_ones = &expo;
  assign exp_zero = ~|expo;
  assign frac_nz  = |frac;

  always_comb begin
    cls.sign      = val[FP_W-1];
    cls.is_nan    = exp_ones & frac_nz;
    cls.is_snan   = exp_ones & frac_nz & ~frac[FRAC_W-1];
    cls.is_zero   = exp_zero & ~frac_nz;
    cls.is_denorm = exp_zero & frac_nz;
  end

  assign mag = val[FP_W-2:0];
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int FP_W = 64
) (
  input  opnd_class_t     cls_a,
  input  opnd_class_t     cls_b,
  input  logic [FP_W-2:0] mag_a,
  input  logic [FP_W-2:0] mag_b,
  output cmp_res_e        res
);
  logic mag_eq, mag_gt, both_neg;

  assign mag_eq   = (mag_a == mag_b);
  assign mag_gt   = (mag_a > mag_b);
  assign both_neg = cls_a.sign & cls_b.sign;

  always_comb begin
    if (cls_a.is_nan || cls_b.is_nan)
      res = CMP_UN;
    else if (cls_a.is_zero && cls_b.is_zero)
      res = CMP_EQ;
    else if (cls_a.sign != cls_b.sign)
      res = cls_a.sign ? CMP_LT : CMP_GT;
    else if (mag_eq)
      res = CMP_EQ;
    else if (mag_gt ^ both_neg)
      res = CMP_GT;
    else
      res = CMP_LT;
  end
endmodule

// File: rtl/fcmp_except.sv
module fcmp_except
  import fcmp_pkg::*;
(
  input  opnd_class_t cls_a,
  input  opnd_class_t cls_b,
  input  logic        sig_mode,
  input  logic        mask_inv,
  input  logic        mask_den,
  output logic        inv,
  output logic        den,
  output logic        unmasked
);
  logic any_nan, any_snan;

  assign any_nan  = cls_a.is_nan | cls_b.is_nan;
  assign any_snan = cls_a.is_snan | cls_b.is_snan;
  assign inv      = sig_mode ? any_nan : any_snan;
  assign den      = cls_a.is_denorm | cls_b.is_denorm;
  assign unmasked = (inv & ~mask_inv) | (den & ~mask_den);
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int OPND_W = 128,
  parameter int FP_W   = 64,
  parameter int EXP_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPND_W-1:0] opnd_a,
  input  logic [OPND_W-1:0] opnd_b,
  input  logic              sig_mode,
  input  logic              mask_inv,
  input  logic              mask_den,
  output logic              out_valid,
  output logic              flag_we,
  output logic              exc_req,
  output logic              exc_inv,
  output logic              exc_den,
  output logic              flag_zf,
  output logic              flag_pf,
  output logic              flag_cf,
  output logic              flag_of,
  output logic              flag_sf,
  output logic              flag_af
);
  localparam int NUM_OPND = 2;

  logic [NUM_OPND-1:0][FP_W-1:0] low_val;
  opnd_class_t                   cls [NUM_OPND];
  logic [FP_W-2:0]               mag [NUM_OPND];

  assign low_val[0] = opnd_a[FP_W-1:0];
  assign low_val[1] = opnd_b[FP_W-1:0];

  generate
    if (OPND_W > FP_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^{opnd_a[OPND_W-1:FP_W], opnd_b[OPND_W-1:FP_W]};
    end
    for (genvar i = 0; i < NUM_OPND; i++) begin : g_cls
      fcmp_classify #(.FP_W(FP_W), .EXP_W(EXP_W)) i_cls (
        .val (low_val[i]),
        .cls (cls[i]),
        .mag (mag[i])
      );
    end
  endgenerate

  cmp_res_e res;
  logic inv_c, den_c, unmasked_c;

  fcmp_order #(.FP_W(FP_W)) i_order (
    .cls_a (cls[0]),
    .cls_b (cls[1]),
    .mag_a (mag[0]),
    .mag_b (mag[1]),
    .res   (res)
  );

  fcmp_except i_except (
    .cls_a    (cls[0]),
    .cls_b    (cls[1]),
    .sig_mode (sig_mode),
    .mask_inv (mask_inv),
    .mask_den (mask_den),
    .inv      (inv_c),
    .den      (den_c),
    .unmasked (unmasked_c)
  );

  logic [2:0] cc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      flag_we   <= 1'b0;
      exc_req   <= 1'b0;
      exc_inv   <= 1'b0;
      exc_den   <= 1'b0;
      cc_q      <= 3'b000;
    end else begin
      out_valid <= in_valid;
      flag_we   <= in_valid & ~unmasked_c;
      exc_req   <= in_valid & unmasked_c;
      if (in_valid) begin
        exc_inv <= inv_c;
        exc_den <= den_c;
        if (!unmasked_c) cc_q <= cc_of(res);
      end
    end
  end

  assign {flag_zf, flag_pf, flag_cf} = cc_q;
  assign flag_of = 1'b0;
  assign flag_sf = 1'b0;
  assign flag_af = 1'b0;

  AST_CC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    flag_we |-> (cc_q inside {3'b000, 3'b001, 3'b100, 3'b111})); // R3
  AST_NAN_UNORD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (cls[0].is_nan || cls[1].is_nan) && !unmasked_c)
      |=> (flag_zf && flag_pf && flag_cf)); // R4
  AST_ZERO_EQ: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls[0].is_zero && cls[1].is_zero && !unmasked_c)
      |=> (flag_zf && !flag_pf && !flag_cf)); // R5
  AST_QUIET_INV: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sig_mode && !cls[0].is_snan && !cls[1].is_snan)
      |=> !exc_inv); // R7
  AST_DEN_SEEN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (cls[0].is_denorm || cls[1].is_denorm)) |=> exc_den); // R8
  AST_WE_XOR_REQ: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot({flag_we, exc_req})); // R9
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !flag_we |-> $stable(cc_q)); // R9
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> !out_valid); // R2
endmodule

// File: tb/test_fcmp_flag_unit.sv
module test_fcmp_flag_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, in_valid, sig_mode, mask_inv, mask_den;
  logic [127:0] opnd_a, opnd_b;
  logic out_valid, flag_we, exc_req, exc_inv, exc_den;
  logic flag_zf, flag_pf, flag_cf, flag_of, flag_sf, flag_af;

  fcmp_flag_unit i_fcmp_flag_unit (.*);

  int errors = 0, checks = 0;
  string cur_req = "R10";
  bit done = 0;

  logic e_valid, e_we, e_req, e_inv, e_den;
  logic [2:0] e_cc;

  function automatic bit f_nan(logic [63:0] v);
    return v[62:52] == 11'h7FF && v[51:0] != 0;
  endfunction
  function automatic bit f_den(logic [63:0] v);
    return v[62:52] == 0 && v[51:0] != 0;
  endfunction

  // behavioural reference, updated on each clock edge
  always @(posedge clk) begin
    if (rst) begin
      e_valid = 0; e_we = 0; e_req = 0; e_inv = 0; e_den = 0; e_cc = 0;
    end else begin
      e_valid = in_valid; e_we = 0; e_req = 0;
      if (in_valid) begin
        logic [63:0] a, b;
        real ra, rb;
        bit inv, den, trap;
        logic [2:0] cc;
        a = opnd_a[63:0]; b = opnd_b[63:0];
        ra = $bitstoreal(a); rb = $bitstoreal(b);
        if (f_nan(a) || f_nan(b)) cc = 3'b111;
        else if (ra == rb) cc = 3'b100;
        else if (ra > rb) cc = 3'b000;
        else cc = 3'b001;
        if (sig_mode) inv = f_nan(a) || f_nan(b);
        else inv = (f_nan(a) && !a[51]) || (f_nan(b) && !b[51]);
        den = f_den(a) || f_den(b);
        trap = (inv && !mask_inv) || (den && !mask_den);
        e_inv = inv; e_den = den;
        e_req = trap; e_we = !trap;
        if (!trap) e_cc = cc;
      end
    end
  end

  task automatic compare();
    logic [10:0] act, exp;
    act = {out_valid, flag_we, exc_req, exc_inv, exc_den,
           flag_zf, flag_pf, flag_cf, flag_of, flag_sf, flag_af};
    exp = {e_valid, e_we, e_req, e_inv, e_den, e_cc, 3'b000};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b t=%0t", cur_req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  int seq = 0;
  task automatic apply(logic [63:0] a, logic [63:0] b, bit mode, bit mi, bit md,
                       string req);
    seq++;
    opnd_a = {64'hA5C3_0000_0000_0000 ^ 64'(seq * 977), a};
    opnd_b = {64'h3C5A_FFFF_0000_0000 ^ 64'(seq * 131), b};
    sig_mode = mode; mask_inv = mi; mask_den = md;
    in_valid = 1; cur_req = req;
    step();
    in_valid = 0;
    step();
  endtask

  localparam logic [63:0] P1 = 64'h3FF0000000000000, P2 = 64'h4000000000000000,
    N1 = 64'hBFF0000000000000, N2 = 64'hC000000000000000,
    PZ = 64'h0, NZ = 64'h8000000000000000,
    PI = 64'h7FF0000000000000, NI = 64'hFFF0000000000000,
    QN = 64'h7FF8000000000000, SN = 64'h7FF0000000000001,
    D1 = 64'h0000000000000001, D2 = 64'h0000000000000002,
    ND = 64'h8000000000000001, MX = 64'h7FEFFFFFFFFFFFFF;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] grid [12];
    grid = '{P1, P2, N1, N2, PZ, NZ, PI, NI, QN, SN, D1, ND};
    rst = 1; in_valid = 0; opnd_a = '0; opnd_b = '0;
    sig_mode = 0; mask_inv = 1; mask_den = 1;
    cur_req = "R10";
    repeat (3) step();
    rst = 0;
    step();
    apply(P2, P1, 0, 1, 1, "R3 gt");
    apply(P1, P2, 0, 1, 1, "R3 lt");
    apply(P1, P1, 0, 1, 1, "R1 equal low bits, upper differ");
    apply(PZ, NZ, 0, 1, 1, "R5");
    apply(NZ, PZ, 0, 1, 1, "R5");
    apply(NZ, NZ, 0, 1, 1, "R5");
    apply(N2, N1, 0, 1, 1, "R6 negative reversed");
    apply(PI, MX, 0, 1, 1, "R6 infinity largest");
    apply(NI, N2, 0, 1, 1, "R6 neg infinity");
    apply(D2, D1, 0, 1, 1, "R6 denormal magnitude");
    apply(ND, PZ, 0, 1, 1, "R6 neg denormal");
    apply(QN, P1, 0, 1, 1, "R4 quiet nan");
    apply(P1, SN, 0, 1, 1, "R4 signalling nan");
    apply(QN, P1, 0, 0, 1, "R7 quiet mode qnan no invalid");
    apply(QN, P1, 1, 0, 1, "R7 R9 sig mode qnan unmasked");
    apply(P1, P1, 0, 1, 1, "R9 restore");
    apply(SN, P1, 0, 0, 1, "R7 R9 snan unmasked keeps flags");
    apply(D1, P1, 0, 1, 0, "R8 R9 denormal unmasked");
    apply(D1, SN, 0, 1, 1, "R8 both masked");
    // back-to-back operations
    cur_req = "R2";
    opnd_a = {64'h1, P1}; opnd_b = {64'h2, P2};
    sig_mode = 0; mask_inv = 1; mask_den = 1; in_valid = 1;
    step();
    opnd_a = {64'h3, N1}; opnd_b = {64'h4, N2};
    step();
    in_valid = 0;
    repeat (3) step();
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        apply(grid[i], grid[j], (i + j) % 2 == 1, j % 3 != 0, i % 3 != 1,
              "R6 grid");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule